// File: doc/BRIEF.md
# Power-Unit Event and Interrupt Controller

This block collects the event sources of a power management unit into two 16-bit pending banks, qualifies them with two matching enable banks and a master enable, and drives a single active-high level interrupt toward the host processor. Internal sources such as thermal alarms, clock alarms, supply failures and threshold-detector crossings arrive as single-cycle pulses. Five general-purpose input pins are resynchronised and turned into events, each according to its own 2-bit event mode.

Software reaches the event-select, pin-level, pending and enable registers through a simple synchronous register port. A handler reads the pending banks and acknowledges exactly what it saw by writing back the complement of the value it read. A zero bit clears, a one bit leaves the bit as it was. Pending bits latch whether or not they are enabled, so software can poll sources it does not want as interrupts.

Top module: `pmu_evt_ctrl`

## Requirements
- R1: After reset every register reads zero, `irq_o` is low, `reg_rdata` is zero and every pin is in level-high mode.
- R2: A one-cycle pulse on a used source bit sets the matching pending bit at the next clock edge, whatever the enable bits hold. The used bits are `src0_i` bits 0-2 and 6-14, and `src1_i` bits 2-5. They land in pending 0 (address 0x03) and pending 1 (address 0x04) at the same bit positions.
- R3: `src0_i` bits 3-5 and 15 and `src1_i` bits 0, 1 and 6-15 have no effect on any pending bit.
- R4: A write to a pending register clears each bit written 0 and keeps each bit written 1. A write never sets a bit.
- R5: If a source event and a clearing write hit the same bit in the same cycle, the bit stays set.
- R6: `irq_o` is high exactly when enable 0 bit 15 (the master enable) is set and some pending bit is set together with its enable bit. Bit 15 of bank 0 is excluded from this. The line stays high until every such bit is cleared or disabled.
- R7: Enable 0 (address 0x05) holds all 16 bits. Enable 1 (address 0x06) and pending 1 hold only bits 5:0, and their higher bits read zero.
- R8: Each pin passes through a two-flop synchroniser. Address 0x02 returns the synchronised pin values in bits 4:0 and ignores writes. Pins 0-2 map to pending 0 bits 3-5, and pins 3-4 map to pending 1 bits 0-1.
- R9: The event-select register at address 0x01 holds the mode of pin n in bits [2n+1:2n]. Code 00 is level high, 01 is level low, 10 is both edges and 11 is falling edge. Bits 15:10 read zero.
- R10: In a level mode the pending bit is set again on every cycle in which the level is active, so clearing it while the level holds leaves it set.
- R11: In both-edge mode every transition of the synchronised pin sets the bit. In falling mode only a 1-to-0 transition sets it, and a rising transition does nothing.
- R12: A read access (`reg_en`=1, `reg_we`=0) puts the register value on `reg_rdata` after the next edge, and `reg_rdata` holds between reads. Unmapped addresses read zero and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src0_i | input | 16 | Event pulses for bank 0 |
| src1_i | input | 16 | Event pulses for bank 1 |
| gpio_pin_i | input | 5 | Asynchronous general-purpose input pins |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Access is a write when high |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq_o | output | 1 | Active-high level interrupt to the host |

## Verification
On every cycle the assertions check these properties of the pending banks and the interrupt line:
- a pending bit only rises when its set vector was active in the cycle before;
- a pending bit only falls when it was written as zero;
- a source event always lands in its bit;
- unimplemented bits stay zero;
- the interrupt is never high without the master enable or without an enabled pending bit;
- read data holds between reads.

The bench scenarios cover the parts that depend on sequences: the bit mapping of each source, the acknowledge-by-complement pattern, the synchroniser latency, each of the four pin modes (including the ignored rising edge in falling mode and the re-set of a held level), and the collision between an event and a clear.

// File: rtl/pmu_evt_pkg.sv
package pmu_evt_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 8;
    localparam int NGPIO  = 5;
    localparam int MODE_W = 2;
    localparam int SEL_W  = NGPIO * MODE_W;
    localparam int MASTER_BIT = 15;

    localparam logic [ADDR_W-1:0] A_EVSEL = 8'h01;
    localparam logic [ADDR_W-1:0] A_PINS  = 8'h02;
    localparam logic [ADDR_W-1:0] A_PEND0 = 8'h03;
    localparam logic [ADDR_W-1:0] A_PEND1 = 8'h04;
    localparam logic [ADDR_W-1:0] A_EN0   = 8'h05;
    localparam logic [ADDR_W-1:0] A_EN1   = 8'h06;

    // source bits that feed each bank directly
    localparam logic [DATA_W-1:0] SRC0_USED  = 16'h7FC7;
    localparam logic [DATA_W-1:0] SRC1_USED  = 16'h003C;
    localparam logic [DATA_W-1:0] BANK0_IMPL = 16'hFFFF;
    localparam logic [DATA_W-1:0] BANK1_IMPL = 16'h003F;

    typedef enum logic [MODE_W-1:0] {
        MODE_LVL_HI = 2'b00,
        MODE_LVL_LO = 2'b01,
        MODE_BOTH   = 2'b10,
        MODE_FALL   = 2'b11
    } pin_mode_e;

    function automatic logic [DATA_W-1:0] pins_to_bank0(input logic [NGPIO-1:0] e);
        return {{(DATA_W-6){1'b0}}, e[2:0], 3'b000};
    endfunction

    function automatic logic [DATA_W-1:0] pins_to_bank1(input logic [NGPIO-1:0] e);
        return {{(DATA_W-2){1'b0}}, e[4:3]};
    endfunction
endpackage

// File: rtl/pmu_gpio_evt.sv
module pmu_gpio_evt #(
    parameter int NPIN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   pin_i,
    input  logic [2*NPIN-1:0] mode_i,
    output logic [NPIN-1:0]   level_o,
    output logic [NPIN-1:0]   evt_o
);
    import pmu_evt_pkg::*;

    typedef struct packed {
        logic [NPIN-1:0] meta;
        logic [NPIN-1:0] sync;
        logic [NPIN-1:0] prev;
    } pin_state_t;

    pin_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pin_i;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        pin_mode_e mode;
        assign mode = pin_mode_e'(mode_i[MODE_W*i +: MODE_W]);
        always_comb begin
            unique case (mode)
                MODE_LVL_HI: evt_o[i] = st_q.sync[i];
                MODE_LVL_LO: evt_o[i] = !st_q.sync[i];
                MODE_BOTH:   evt_o[i] = st_q.sync[i] ^ st_q.prev[i];
                MODE_FALL:   evt_o[i] = st_q.prev[i] & !st_q.sync[i];
                default:     evt_o[i] = 1'b0;
            endcase
        end
    end

    assign level_o = st_q.sync;
endmodule

// File: rtl/pmu_pend_bank.sv
module pmu_pend_bank #(
    parameter int               W    = 16,
    parameter logic [W-1:0]     IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         pend_wr_i,
    input  logic         en_wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] pend_o,
    output logic [W-1:0] en_o
);
    typedef struct packed {
        logic [W-1:0] pend;
        logic [W-1:0] en;
    } bank_t;

    bank_t bk_d, bk_q;
    logic [W-1:0] keep;

    always_comb begin
        bk_d    = bk_q;
        keep    = pend_wr_i ? wdata_i : '1;
        // write of 0 clears, events always win
        bk_d.pend = ((bk_q.pend & keep) | set_i) & IMPL;
        if (en_wr_i) bk_d.en = wdata_i & IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign pend_o = bk_q.pend;
    assign en_o   = bk_q.en;
endmodule

// File: rtl/pmu_evt_ctrl.sv
module pmu_evt_ctrl
    import pmu_evt_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] src0_i,
    input  logic [DW-1:0] src1_i,
    input  logic [NGPIO-1:0] gpio_pin_i,
    input  logic          reg_en,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_o
);
    typedef struct packed {
        logic [SEL_W-1:0] evsel;
        logic [DW-1:0]    rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NGPIO-1:0] pin_lvl_w, pin_evt_w;
    logic [DW-1:0] set0_w, set1_w;
    logic [DW-1:0] pend0_w, pend1_w, en0_w, en1_w;
    logic wr_w, rd_w;
    logic wr_p0, wr_p1, wr_e0, wr_e1;
    logic [DW-1:0] rmux;
    logic [DW-1:0] hit0, hit1;

    assign wr_w  = reg_en && reg_we;
    assign rd_w  = reg_en && !reg_we;
    assign wr_p0 = wr_w && (reg_addr == AW'(A_PEND0));
    assign wr_p1 = wr_w && (reg_addr == AW'(A_PEND1));
    assign wr_e0 = wr_w && (reg_addr == AW'(A_EN0));
    assign wr_e1 = wr_w && (reg_addr == AW'(A_EN1));

    pmu_gpio_evt #(.NPIN(NGPIO)) u_gpio (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (gpio_pin_i),
        .mode_i  (ctl_q.evsel),
        .level_o (pin_lvl_w),
        .evt_o   (pin_evt_w)
    );

    assign set0_w = (src0_i & SRC0_USED) | pins_to_bank0(pin_evt_w);
    assign set1_w = (src1_i & SRC1_USED) | pins_to_bank1(pin_evt_w);

    pmu_pend_bank #(.W(DW), .IMPL(BANK0_IMPL)) u_bank0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set0_w),
        .pend_wr_i (wr_p0),
        .en_wr_i   (wr_e0),
        .wdata_i   (reg_wdata),
        .pend_o    (pend0_w),
        .en_o      (en0_w)
    );

    pmu_pend_bank #(.W(DW), .IMPL(BANK1_IMPL)) u_bank1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set1_w),
        .pend_wr_i (wr_p1),
        .en_wr_i   (wr_e1),
        .wdata_i   (reg_wdata),
        .pend_o    (pend1_w),
        .en_o      (en1_w)
    );

    always_comb begin
        unique case (reg_addr)
            AW'(A_EVSEL): rmux = DW'(ctl_q.evsel);
            AW'(A_PINS):  rmux = DW'(pin_lvl_w);
            AW'(A_PEND0): rmux = pend0_w;
            AW'(A_PEND1): rmux = pend1_w;
            AW'(A_EN0):   rmux = en0_w;
            AW'(A_EN1):   rmux = en1_w;
            default:      rmux = '0;
        endcase
    end

    always_comb begin
        ctl_d = ctl_q;
        if (wr_w && reg_addr == AW'(A_EVSEL)) ctl_d.evsel = reg_wdata[SEL_W-1:0];
        if (rd_w) ctl_d.rdata = rmux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign hit0 = pend0_w & en0_w & ~(DW'(1) << MASTER_BIT);
    assign hit1 = pend1_w & en1_w;
    assign irq_o     = en0_w[MASTER_BIT] && (|{hit0, hit1});
    assign reg_rdata = ctl_q.rdata;
endmodule

// File: rtl/pmu_evt_ctrl_chk.sv
module pmu_evt_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        irq_o,
    input logic        reg_en,
    input logic        reg_we,
    input logic [7:0]  reg_addr,
    input logic [15:0] reg_wdata,
    input logic [15:0] reg_rdata,
    input logic [15:0] pend0,
    input logic [15:0] pend1,
    input logic [15:0] en0,
    input logic [15:0] en1,
    input logic [15:0] set0,
    input logic [15:0] set1
);
    logic [15:0] clr0, clr1;
    assign clr0 = (reg_en && reg_we && reg_addr == 8'h03) ? ~reg_wdata : 16'h0000;
    assign clr1 = (reg_en && reg_we && reg_addr == 8'h04) ? ~reg_wdata : 16'h0000;

    // R6
    irq_needs_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en0[15] |-> !irq_o);

    // R6
    irq_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((pend0 & en0 & 16'h7FFF) == 16'h0) && ((pend1 & en1) == 16'h0)) |-> !irq_o);

    // R7
    bank1_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend1 | en1) & 16'hFFC0) == 16'h0);

    // R4
    pend_no_stray_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pend0 & ~$past(pend0) & ~$past(set0)) == 16'h0) &&
                  ((pend1 & ~$past(pend1) & ~$past(set1)) == 16'h0)));

    // R4
    pend_drop_needs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((($past(pend0) & ~pend0) & ~$past(clr0)) == 16'h0) &&
                  ((($past(pend1) & ~pend1) & ~$past(clr1)) == 16'h0)));

    // R5
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(set0) & ~pend0) == 16'h0) && (($past(set1) & ~pend1) == 16'h0)));

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_en && !reg_we) |=> $stable(reg_rdata));
endmodule

bind pmu_evt_ctrl pmu_evt_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_o     (irq_o),
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pend0     (pend0_w),
    .pend1     (pend1_w),
    .en0       (en0_w),
    .en1       (en1_w),
    .set0      (set0_w),
    .set1      (set1_w)
);

// File: tb/pmu_evt_ctrl_tb.sv
`timescale 1ns/1ps
module pmu_evt_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src0 = '0, src1 = '0;
    logic [4:0]  pins = '0;
    logic        reg_en = 1'b0, reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pmu_evt_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .src0_i     (src0),
        .src1_i     (src1),
        .gpio_pin_i (pins),
        .reg_en     (reg_en),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_o      (irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_en = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [15:0] s0, input logic [15:0] s1);
        @(negedge clk);
        src0 = s0; src1 = s1;
        @(negedge clk);
        src0 = '0; src1 = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 irq", {15'b0, irq}, 16'h0);
        check("R1 rdata", reg_rdata, 16'h0);
        for (int a = 1; a <= 6; a++) begin
            rd(8'(a), v);
            check("R1 reg", v, 16'h0);
        end
    endtask

    task automatic t_latch();
        logic [15:0] v;
        pulse(16'h7FC7, 16'h0000);
        rd(8'h03, v);
        check("R2 pend0 latch while disabled", v, 16'h7FC7);
        check("R2 no irq when disabled", {15'b0, irq}, 16'h0);
        wr(8'h03, 16'h0000);
        pulse(16'h8038, 16'hFFC3);
        rd(8'h03, v);
        check("R3 pend0 ignores unused src", v, 16'h0000);
        rd(8'h04, v);
        check("R3 pend1 ignores unused src", v, 16'h0000);
        pulse(16'h0000, 16'hFFFF);
        rd(8'h04, v);
        check("R2 pend1 latch", v, 16'h003C);
    endtask

    task automatic t_clear();
        logic [15:0] v;
        pulse(16'h7FC7, 16'h0000);
        wr(8'h03, 16'hFFBE);
        rd(8'h03, v);
        check("R4 complement ack", v, 16'h7F86);
        wr(8'h03, 16'hFFFF);
        rd(8'h03, v);
        check("R4 ones keep", v, 16'h7F86);
        wr(8'h03, 16'h0000);
        wr(8'h04, 16'h0000);
        rd(8'h03, v);
        check("R4 zero clears pend0", v, 16'h0000);
        rd(8'h04, v);
        check("R4 zero clears pend1", v, 16'h0000);
    endtask

    task automatic t_irq();
        pulse(16'h0002, 16'h0000);
        wr(8'h05, 16'h0002);
        check("R6 no master", {15'b0, irq}, 16'h0);
        wr(8'h05, 16'h8002);
        check("R6 master and hit", {15'b0, irq}, 16'h1);
        wr(8'h05, 16'h8000);
        check("R6 source disabled", {15'b0, irq}, 16'h0);
        wr(8'h05, 16'h8002);
        idle(3);
        check("R6 level holds", {15'b0, irq}, 16'h1);
        wr(8'h03, 16'h0000);
        check("R6 drops on clear", {15'b0, irq}, 16'h0);
        wr(8'h06, 16'h0004);
        pulse(16'h0000, 16'h0004);
        check("R6 bank1 irq", {15'b0, irq}, 16'h1);
        wr(8'h04, 16'h0000);
        check("R6 bank1 clear", {15'b0, irq}, 16'h0);
        wr(8'h05, 16'h0000);
        wr(8'h06, 16'h0000);
    endtask

    task automatic t_race();
        logic [15:0] v;
        pulse(16'h0002, 16'h0000);
        @(negedge clk);
        src0 = 16'h0002;
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = 8'h03; reg_wdata = 16'h0000;
        @(negedge clk);
        src0 = '0; reg_en = 1'b0; reg_we = 1'b0;
        rd(8'h03, v);
        check("R5 event beats clear", v, 16'h0002);
        wr(8'h03, 16'h0000);
    endtask

    task automatic t_widths();
        logic [15:0] v;
        wr(8'h05, 16'hFFFF);
        rd(8'h05, v);
        check("R7 en0 full width", v, 16'hFFFF);
        wr(8'h05, 16'h0000);
        wr(8'h06, 16'hFFFF);
        rd(8'h06, v);
        check("R7 en1 width", v, 16'h003F);
        wr(8'h06, 16'h0000);
        wr(8'h01, 16'hFC00);
        rd(8'h01, v);
        check("R9 evsel upper zero", v, 16'h0000);
        wr(8'h07, 16'hFFFF);
        rd(8'h07, v);
        check("R12 unmapped reads zero", v, 16'h0000);
        wr(8'h02, 16'hFFFF);
        rd(8'h02, v);
        check("R8 pin reg ignores write", v, 16'h0000);
        rd(8'h01, v);
        check("R12 unmapped write no effect", v, 16'h0000);
        idle(2);
        check("R12 rdata held", reg_rdata, 16'h0000);
    endtask

    task automatic t_level();
        logic [15:0] v;
        @(negedge clk); pins = 5'b00001;
        idle(4);
        rd(8'h02, v);
        check("R8 synchronised pin", v, 16'h0001);
        rd(8'h03, v);
        check("R8 pin0 to pend0 bit3", v, 16'h0008);
        wr(8'h03, 16'h0000);
        rd(8'h03, v);
        check("R10 level re-sets", v, 16'h0008);
        @(negedge clk); pins = 5'b00000;
        idle(4);
        wr(8'h03, 16'h0000);
        rd(8'h03, v);
        check("R10 clears after level gone", v, 16'h0000);
        wr(8'h01, 16'h0040);
        idle(2);
        rd(8'h04, v);
        check("R9 level-low pin3", v, 16'h0001);
        wr(8'h01, 16'h0000);
        wr(8'h04, 16'h0000);
        rd(8'h04, v);
        check("R9 level-high pin3 quiet", v, 16'h0000);
    endtask

    task automatic t_edge();
        logic [15:0] v;
        wr(8'h01, 16'h020C);
        rd(8'h01, v);
        check("R9 evsel readback", v, 16'h020C);
        @(negedge clk); pins = 5'b00010;
        idle(4);
        rd(8'h03, v);
        check("R11 falling ignores rise", v, 16'h0000);
        @(negedge clk); pins = 5'b00000;
        idle(4);
        rd(8'h03, v);
        check("R11 falling fires", v, 16'h0010);
        wr(8'h03, 16'h0000);
        rd(8'h03, v);
        check("R11 edge clear sticks", v, 16'h0000);
        @(negedge clk); pins = 5'b10000;
        idle(4);
        rd(8'h04, v);
        check("R11 both rise pin4", v, 16'h0002);
        wr(8'h04, 16'h0000);
        @(negedge clk); pins = 5'b00000;
        idle(4);
        rd(8'h04, v);
        check("R11 both fall pin4", v, 16'h0002);
        wr(8'h04, 16'h0000);
    endtask

    initial begin
        fork
            begin
                idle(3);
                @(negedge clk); rst_n = 1'b1;
                t_reset();
                t_latch();
                t_clear();
                t_irq();
                t_race();
                t_widths();
                t_level();
                t_edge();
            end
            begin
                repeat (20000) @(posedge clk);
                fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule